// File: doc/BRIEF.md
# PATA PIO bus cycle generator

This block converts single register accesses from a host into programmed-I/O bus cycles toward a parallel ATA device on a 16-bit data bus. The host presents one request at a time: a register offset, a direction, write data and an 8/16-bit size flag, qualified by `req_valid`/`req_ready`. The block then frames the cycle on the device side. It drives the chip selects and the 3-bit register address, generates the read or write strobe, and gives a one-clock `rsp_done` with the read result when the cycle ends.

Cycle timing comes from three clock-count values: strobe setup, strobe pulse and total cycle length. Software loads them into shadow registers at any time. The sequencer copies them when it accepts a request, so a load takes effect from the next cycle. The sequencer always adds one clock to the setup and stretches the cycle when needed so that recovery is never shorter than two clocks. It frames the chip select one clock inside each end of the cycle. It holds the strobe while the device signals not-ready. Register index n lives at host byte offset 2n. The top address bit selects between the command block and the control block. 8-bit accesses use only the low byte lane.

The controller is a four-state machine. IDLE moves to SETUP on ACCEPT (`req_valid` while idle). SETUP moves to STROBE on SETUP_DONE (effective setup count reached). STROBE moves to RECOVER on PULSE_DONE (pulse count reached with the device ready). RECOVER returns to IDLE on RECOVERY_DONE (recovery count reached, the clock in which `rsp_done` is high).

Top module: `pata_pio_engine`

## Requirements
- R1: After reset `req_ready` is 1, both chip selects and both strobes are high (inactive), `rsp_done` is 0, and the timing registers hold 4 setup, 15 pulse and 30 cycle clocks (70/290/600 ns at 20 ns per clock), giving a 30-clock cycle.
- R2: Counting the first clock after acceptance as clock 0, the strobe first goes low in clock S+1, where S is the programmed setup.
- R3: With the device ready, the strobe stays low for exactly P clocks, where P is the programmed pulse; P of 0 is treated as 1.
- R4: A cycle lasts max(C, S+1+P+2) clocks, where C is the programmed cycle, plus any not-ready clocks. `rsp_done` is high only in the last clock. `req_ready` is low from clock 0 through the done clock and high in the clock after.
- R5: The number of clocks from the strobe's deassertion to the end of the cycle is never below 2.
- R6: The selected chip select is low from clock 1 up to and including clock total−2, so it is low for total−2 clocks.
- R7: Writes use the same framing as reads. `ata_diow_n` is the strobe, `ata_dd_oe` is high while it is low, and `ata_dd_out` carries the full word for 16-bit writes or {0x00, low byte} for 8-bit writes.
- R8: Read data is taken from `ata_dd_in` at the clock edge on which `ata_dior_n` returns high. `rsp_rdata` returns the full word for 16-bit reads and {0x00, low byte} for 8-bit reads.
- R9: Every clock of the strobe in which `ata_iordy` is low adds one clock to the strobe width and to the cycle.
- R10: `ata_da` equals `req_addr[3:1]`. `req_addr[4]`=0 activates `ata_cs0_n` only (command block). `req_addr[4]`=1 activates `ata_cs1_n` only (control block, e.g. index 6 at offset 0x1C).
- R11: A timing load, including one in the same clock as ACCEPT, has no effect on the cycle in progress and applies from the next accepted request.
- R12: The two strobes are never low together, and a strobe is low only while exactly one chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 4 | Byte offset bits [4:1]: bit 4 block select, [3:1] register index |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit on low lane |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| tim_load | input | 1 | Load the three timing shadow registers |
| tim_setup | input | 8 | Strobe setup in clocks (before the forced extra clock) |
| tim_pulse | input | 8 | Strobe pulse in clocks |
| tim_cycle | input | 8 | Total cycle in clocks |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data driven to the device |
| ata_dd_oe | output | 1 | Output enable for ata_dd_out |
| ata_dd_in | input | 16 | Data from the device |
| ata_iordy | input | 1 | Device ready; low stretches the strobe |

## Verification
Two pairs of events can land in one clock, and each pair decides the cycle shape. First, a timing load can arrive in the same clock as ACCEPT. The bench drives `tim_load` and `req_valid` at the same sampling point and expects the old setup, pulse and length for that cycle and the new ones for the following cycle. Second, a not-ready indication can coincide with the clock in which the pulse count completes. The device model holds `ata_iordy` low for the first k strobe clocks, including cases where k meets or exceeds the pulse, and the scoreboard expects the width and cycle to grow by exactly k with the read word still captured at the strobe's rising edge.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    // Width of the device register index
    localparam int REG_IDX_W = 3;
    // Width of one byte lane on the device data bus
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } pio_state_e;

    // Latched request attributes for the cycle in flight
    typedef struct packed {
        logic                 ctl;   // 1: control block (CS1), 0: command block (CS0)
        logic [REG_IDX_W-1:0] idx;   // device register index
        logic                 we;    // write cycle
        logic                 wide;  // 16-bit transfer
    } pio_cmd_t;

endpackage

// File: rtl/pata_timing_regs.sv
module pata_timing_regs #(
    parameter int TW        = 8,
    parameter int CLK_NS    = 20,
    parameter int SETUP_NS  = 70,
    parameter int PULSE_NS  = 290,
    parameter int CYCLE_NS  = 600,
    parameter int EXTRA_SU  = 1,
    parameter int MIN_REC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] setup_in,
    input  logic [TW-1:0] pulse_in,
    input  logic [TW-1:0] cycle_in,
    output logic [TW:0]   eff_setup,
    output logic [TW-1:0] eff_pulse,
    output logic [TW+1:0] rec_len
);

    localparam int RST_SETUP = (SETUP_NS + CLK_NS - 1) / CLK_NS;
    localparam int RST_PULSE = (PULSE_NS + CLK_NS - 1) / CLK_NS;
    localparam int RST_CYCLE = (CYCLE_NS + CLK_NS - 1) / CLK_NS;
    localparam int SW        = TW + 2;

    logic [TW-1:0] sh_setup;
    logic [TW-1:0] sh_pulse;
    logic [TW-1:0] sh_cycle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_setup <= TW'(RST_SETUP);
            sh_pulse <= TW'(RST_PULSE);
            sh_cycle <= TW'(RST_CYCLE);
        end else if (load) begin
            sh_setup <= setup_in;
            sh_pulse <= pulse_in;
            sh_cycle <= cycle_in;
        end
    end

    logic [SW-1:0] active;
    logic [SW-1:0] floor_len;
    logic [SW-1:0] cyc_w;

    always_comb begin
        eff_setup = {1'b0, sh_setup} + (TW+1)'(EXTRA_SU);
        eff_pulse = (sh_pulse == '0) ? TW'(1) : sh_pulse;
        active    = {1'b0, eff_setup} + {2'b00, eff_pulse};
        floor_len = active + SW'(MIN_REC);
        cyc_w     = {2'b00, sh_cycle};
        if (cyc_w < floor_len) begin
            rec_len = SW'(MIN_REC);
        end else begin
            rec_len = cyc_w - active;
        end
    end

endmodule

// File: rtl/pata_cycle_fsm.sv
module pata_cycle_fsm
    import pata_pio_pkg::*;
#(
    parameter int TW     = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              is_write,
    input  logic [TW:0]       eff_setup,
    input  logic [TW-1:0]     eff_pulse,
    input  logic [TW+1:0]     rec_len,
    input  logic              iordy,
    input  logic [DATA_W-1:0] dd_in,
    output logic              ready,
    output logic              done,
    output logic              cs_on,
    output logic              rd_on,
    output logic              wr_on,
    output logic              oe_on,
    output logic [DATA_W-1:0] cap_data
);

    localparam int CW = TW + 2;

    pio_state_e    state;
    pio_state_e    state_nx;
    logic [CW-1:0] cnt;
    logic [TW:0]   lat_setup;
    logic [TW-1:0] lat_pulse;
    logic [TW+1:0] lat_rec;
    logic          setup_last;
    logic          pulse_last;
    logic          rec_last;
    logic          strobe_on;

    assign setup_last = (cnt == ({1'b0, lat_setup} - CW'(1)));
    assign pulse_last = (cnt == ({2'b00, lat_pulse} - CW'(1)));
    assign rec_last   = (cnt == (lat_rec - CW'(1)));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: ACCEPT, SETUP_DONE, PULSE_DONE, RECOVERY_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_req)            state_nx = ST_SETUP;
            ST_SETUP:   if (setup_last)           state_nx = ST_STROBE;
            ST_STROBE:  if (iordy && pulse_last)  state_nx = ST_RECOVER;
            ST_RECOVER: if (rec_last)             state_nx = ST_IDLE;
        endcase
    end

    // Phase counter; in the strobe it advances only on ready clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_nx != state) begin
            cnt <= '0;
        end else if (state == ST_STROBE) begin
            cnt <= cnt + CW'(iordy);
        end else if (state != ST_IDLE) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Timing snapshot taken on ACCEPT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_setup <= '0;
            lat_pulse <= '0;
            lat_rec   <= '0;
        end else if (state == ST_IDLE && start_req) begin
            lat_setup <= eff_setup;
            lat_pulse <= eff_pulse;
            lat_rec   <= rec_len;
        end
    end

    // Read word taken on the edge that ends the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data <= '0;
        end else if (state == ST_STROBE && state_nx == ST_RECOVER && !is_write) begin
            cap_data <= dd_in;
        end
    end

    // Outputs
    always_comb begin
        ready     = 1'b0;
        done      = 1'b0;
        cs_on     = 1'b0;
        strobe_on = 1'b0;
        unique case (state)
            ST_IDLE:    ready = 1'b1;
            ST_SETUP:   cs_on = (cnt != '0);
            ST_STROBE:  begin
                cs_on     = 1'b1;
                strobe_on = 1'b1;
            end
            ST_RECOVER: begin
                cs_on = !rec_last;
                done  = rec_last;
            end
        endcase
        rd_on = strobe_on && !is_write;
        wr_on = strobe_on && is_write;
        oe_on = is_write && (state != ST_IDLE);
    end

    // R2
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start_req) |=> !strobe_on);

    // R9
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !iordy) |=> (state == ST_STROBE));

    // R5
    recov_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_on) |-> !done);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

endmodule

// File: rtl/pata_lane_map.sv
module pata_lane_map
    import pata_pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 ctl,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic                 wide,
    input  logic                 cs_on,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    cap_data,
    output logic                 cs0_n,
    output logic                 cs1_n,
    output logic [REG_IDX_W-1:0] da,
    output logic [DATA_W-1:0]    dd_out,
    output logic [DATA_W-1:0]    rdata
);

    localparam int LANES = DATA_W / BYTE_W;

    assign cs0_n = !(cs_on && !ctl);
    assign cs1_n = !(cs_on && ctl);
    assign da    = idx;

    // Byte lanes: lane 0 always carries data, upper lanes only on wide access
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign dd_out[BYTE_W-1:0] = wdata[BYTE_W-1:0];
            assign rdata[BYTE_W-1:0]  = cap_data[BYTE_W-1:0];
        end else begin : g_high
            assign dd_out[g*BYTE_W +: BYTE_W] = wide ? wdata[g*BYTE_W +: BYTE_W] : '0;
            assign rdata[g*BYTE_W +: BYTE_W]  = wide ? cap_data[g*BYTE_W +: BYTE_W] : '0;
        end
    end

endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int TW       = 8,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 20,
    parameter int SETUP_NS = 70,
    parameter int PULSE_NS = 290,
    parameter int CYCLE_NS = 600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [REG_IDX_W+1:1] req_addr,
    input  logic                 req_we,
    input  logic                 req_wide,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 tim_load,
    input  logic [TW-1:0]        tim_setup,
    input  logic [TW-1:0]        tim_pulse,
    input  logic [TW-1:0]        tim_cycle,
    output logic                 ata_cs0_n,
    output logic                 ata_cs1_n,
    output logic [REG_IDX_W-1:0] ata_da,
    output logic                 ata_dior_n,
    output logic                 ata_diow_n,
    output logic [DATA_W-1:0]    ata_dd_out,
    output logic                 ata_dd_oe,
    input  logic [DATA_W-1:0]    ata_dd_in,
    input  logic                 ata_iordy
);

    localparam int BLK_BIT = REG_IDX_W + 1;

    logic              accept;
    pio_cmd_t          cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TW:0]       eff_setup;
    logic [TW-1:0]     eff_pulse;
    logic [TW+1:0]     rec_len;
    logic              cs_on;
    logic              rd_on;
    logic              wr_on;
    logic              oe_on;
    logic [DATA_W-1:0] cap_data;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            cmd_q.ctl  <= req_addr[BLK_BIT];
            cmd_q.idx  <= req_addr[REG_IDX_W:1];
            cmd_q.we   <= req_we;
            cmd_q.wide <= req_wide;
            wdata_q    <= req_wdata;
        end
    end

    pata_timing_regs #(
        .TW       (TW),
        .CLK_NS   (CLK_NS),
        .SETUP_NS (SETUP_NS),
        .PULSE_NS (PULSE_NS),
        .CYCLE_NS (CYCLE_NS),
        .EXTRA_SU (1),
        .MIN_REC  (2)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tim_load),
        .setup_in  (tim_setup),
        .pulse_in  (tim_pulse),
        .cycle_in  (tim_cycle),
        .eff_setup (eff_setup),
        .eff_pulse (eff_pulse),
        .rec_len   (rec_len)
    );

    pata_cycle_fsm #(
        .TW     (TW),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (req_valid),
        .is_write  (cmd_q.we),
        .eff_setup (eff_setup),
        .eff_pulse (eff_pulse),
        .rec_len   (rec_len),
        .iordy     (ata_iordy),
        .dd_in     (ata_dd_in),
        .ready     (req_ready),
        .done      (rsp_done),
        .cs_on     (cs_on),
        .rd_on     (rd_on),
        .wr_on     (wr_on),
        .oe_on     (oe_on),
        .cap_data  (cap_data)
    );

    pata_lane_map #(
        .DATA_W (DATA_W)
    ) u_map (
        .ctl      (cmd_q.ctl),
        .idx      (cmd_q.idx),
        .wide     (cmd_q.wide),
        .cs_on    (cs_on),
        .wdata    (wdata_q),
        .cap_data (cap_data),
        .cs0_n    (ata_cs0_n),
        .cs1_n    (ata_cs1_n),
        .da       (ata_da),
        .dd_out   (ata_dd_out),
        .rdata    (rsp_rdata)
    );

    assign ata_dior_n = !rd_on;
    assign ata_diow_n = !wr_on;
    assign ata_dd_oe  = oe_on;

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n));

    // R12
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_dior_n || !ata_diow_n) |-> (ata_cs0_n != ata_cs1_n));

    // R6
    cs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ata_cs0_n && ata_cs1_n && !req_ready));

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_diow_n |-> ata_dd_oe);

endmodule

// File: tb/test_pata_pio_engine.sv
`timescale 1ns/1ps
module test_pata_pio_engine;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [4:1]  req_addr;
    logic        req_we;
    logic        req_wide;
    logic [15:0] req_wdata;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        tim_load;
    logic [7:0]  tim_setup;
    logic [7:0]  tim_pulse;
    logic [7:0]  tim_cycle;
    logic        ata_cs0_n;
    logic        ata_cs1_n;
    logic [2:0]  ata_da;
    logic        ata_dior_n;
    logic        ata_diow_n;
    logic [15:0] ata_dd_out;
    logic        ata_dd_oe;
    logic [15:0] ata_dd_in;
    logic        ata_iordy;

    pata_pio_engine i_pata_pio_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wide   (req_wide),
        .req_wdata  (req_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .tim_load   (tim_load),
        .tim_setup  (tim_setup),
        .tim_pulse  (tim_pulse),
        .tim_cycle  (tim_cycle),
        .ata_cs0_n  (ata_cs0_n),
        .ata_cs1_n  (ata_cs1_n),
        .ata_da     (ata_da),
        .ata_dior_n (ata_dior_n),
        .ata_diow_n (ata_diow_n),
        .ata_dd_out (ata_dd_out),
        .ata_dd_oe  (ata_dd_oe),
        .ata_dd_in  (ata_dd_in),
        .ata_iordy  (ata_iordy)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    typedef struct {
        int setup; int width; int total; int recov;
        int da; bit ctl; bit we; int rdata; int wdata;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_errors = 0;
    int b_s = 4, b_p = 15, b_c = 30;   // bench copy of the timing shadow
    int dev_pattern = 0;
    int dev_stretch = 0;
    int dev_j = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Device model: not-ready for the first dev_stretch strobe clocks
    always @(negedge clk) begin
        if (!ata_dior_n || !ata_diow_n) begin
            ata_iordy = (dev_j < dev_stretch) ? 1'b0 : 1'b1;
            dev_j++;
            if (!ata_dior_n) ata_dd_in = dev_pattern[15:0];
        end else begin
            ata_iordy = 1'b1;
            dev_j = 0;
            ata_dd_in = 16'hBAD0;
        end
    end

    // Monitor / scoreboard
    bit mon_active = 0;
    bit done_prev = 0;
    int mt, m_first, m_width, m_last, m_cs_cnt, m_cs_first, m_cs_last, m_da, m_wr;
    bit m_cs0, m_cs1, m_oe_ok, m_used_w, m_used_r;

    always @(negedge clk) begin
        if (done_prev) begin
            chk(req_ready, "R4 ready after done", req_ready, 1);
            done_prev = 0;
        end
        if (rst_n && !req_ready) begin
            if (!mon_active) begin
                mon_active = 1; mt = 0; m_first = -1; m_width = 0; m_last = -1;
                m_cs_cnt = 0; m_cs_first = -1; m_cs_last = -1; m_da = -1; m_wr = -1;
                m_cs0 = 0; m_cs1 = 0; m_oe_ok = 1; m_used_w = 0; m_used_r = 0;
            end
            if (!ata_dior_n || !ata_diow_n) begin
                if (m_first < 0) m_first = mt;
                m_width++;
                m_last = mt;
                m_da = ata_da;
                if (!ata_diow_n) begin
                    m_used_w = 1; m_wr = ata_dd_out;
                    if (!ata_dd_oe) m_oe_ok = 0;
                end
                if (!ata_dior_n) m_used_r = 1;
            end
            if (!ata_cs0_n || !ata_cs1_n) begin
                m_cs_cnt++;
                if (m_cs_first < 0) m_cs_first = mt;
                m_cs_last = mt;
                if (!ata_cs0_n) m_cs0 = 1;
                if (!ata_cs1_n) m_cs1 = 1;
            end
            if (rsp_done) begin
                exp_t e;
                int tot;
                tot = mt + 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(m_first == e.setup, "R2 strobe start clock", m_first, e.setup);
                    chk(m_width == e.width, "R3/R9 strobe width", m_width, e.width);
                    chk(tot == e.total, "R4 cycle length", tot, e.total);
                    chk((tot - 1 - m_last) == e.recov && e.recov >= 2, "R5 recovery", tot - 1 - m_last, e.recov);
                    chk(m_cs_first == 1 && m_cs_last == tot - 2, "R6 chip-select edges", m_cs_first * 256 + m_cs_last, 256 + tot - 2);
                    chk(m_cs_cnt == tot - 2, "R6 chip-select length", m_cs_cnt, tot - 2);
                    chk(m_da == e.da, "R10 register address", m_da, e.da);
                    chk(m_cs1 == e.ctl && m_cs0 == !e.ctl, "R10 block select", {m_cs1, m_cs0}, {e.ctl, !e.ctl});
                    if (e.we) begin
                        chk(m_used_w && !m_used_r && m_oe_ok, "R7 write strobe and enable", {m_used_w, m_used_r, m_oe_ok}, 3'b101);
                        chk(m_wr == e.wdata, "R7 write lanes", m_wr, e.wdata);
                    end else begin
                        chk(m_used_r && !m_used_w, "R8 read strobe", {m_used_r, m_used_w}, 2'b10);
                        chk(int'(rsp_rdata) == e.rdata, "R8 read data", rsp_rdata, e.rdata);
                    end
                end
                mon_active = 0;
                done_prev = 1;
            end else begin
                mt++;
            end
        end
    end

    task automatic load_timing(input int s, input int p, input int c);
        tim_setup = s[7:0]; tim_pulse = p[7:0]; tim_cycle = c[7:0];
        tim_load = 1'b1;
        @(negedge clk);
        tim_load = 1'b0;
        b_s = s; b_p = p; b_c = c;
    endtask

    task automatic xfer(input bit ctl, input int idx, input bit we, input bit wide,
                        input int wd, input int pat, input int stretch,
                        input bit ld, input int ls, input int lp, input int lc);
        exp_t e;
        int es, ep, tot;
        while (!req_ready) @(negedge clk);
        es = b_s + 1;
        ep = (b_p == 0) ? 1 : b_p;
        tot = (b_c > es + ep + 2) ? b_c : es + ep + 2;
        e.setup = es;
        e.width = ep + stretch;
        e.total = tot + stretch;
        e.recov = tot - es - ep;
        e.da = idx; e.ctl = ctl; e.we = we;
        e.rdata = wide ? (pat & 16'hFFFF) : (pat & 16'h00FF);
        e.wdata = wide ? (wd & 16'hFFFF) : (wd & 16'h00FF);
        exp_q.push_back(e);
        dev_pattern = pat;
        dev_stretch = stretch;
        req_addr = {ctl, idx[2:0]};
        req_we = we; req_wide = wide; req_wdata = wd[15:0];
        req_valid = 1'b1;
        if (ld) begin
            tim_setup = ls[7:0]; tim_pulse = lp[7:0]; tim_cycle = lc[7:0];
            tim_load = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        tim_load = 1'b0;
        if (ld) begin
            b_s = ls; b_p = lp; b_c = lc;
        end
    endtask

    task automatic wait_idle();
        while (!(req_ready && exp_q.size() == 0 && !done_prev)) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_wide = 1'b0;
        req_wdata = '0; tim_load = 1'b0; tim_setup = '0; tim_pulse = '0; tim_cycle = '0;
        ata_dd_in = 16'hBAD0; ata_iordy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_done, "R1 ready/done after reset", {req_ready, rsp_done}, 2'b10);
        chk(ata_cs0_n && ata_cs1_n, "R1 chip selects idle", {ata_cs0_n, ata_cs1_n}, 2'b11);
        chk(ata_dior_n && ata_diow_n, "R1 strobes idle", {ata_dior_n, ata_diow_n}, 2'b11);

        // R1 default timing: 4/15/30 -> 30-clock cycle; R8 wide read
        xfer(0, 0, 0, 1, 0, 16'hA55A, 0, 0, 0, 0, 0);       wait_idle();
        // R8 narrow read of status (index 7)
        xfer(0, 7, 0, 0, 0, 16'h12F3, 0, 0, 0, 0, 0);       wait_idle();
        // R7 narrow write to index 2, wide write to data register
        xfer(0, 2, 1, 0, 16'hABCD, 0, 0, 0, 0, 0, 0);       wait_idle();
        xfer(0, 0, 1, 1, 16'h1234, 0, 0, 0, 0, 0, 0);       wait_idle();
        // R10 control block read, index 6 (offset 0x1C)
        xfer(1, 6, 0, 0, 0, 16'h7750, 0, 0, 0, 0, 0);       wait_idle();

        // R5 clamp: 2/4/6 -> 3+4+2 = 9
        load_timing(2, 4, 6);
        xfer(0, 3, 0, 1, 0, 16'h0F0F, 0, 0, 0, 0, 0);       wait_idle();
        // R9 three not-ready clocks
        xfer(0, 4, 0, 1, 0, 16'hC3C3, 3, 0, 0, 0, 0);       wait_idle();
        // R9 not-ready longer than the pulse, on a write
        xfer(0, 5, 1, 1, 16'h5AA5, 0, 6, 0, 0, 0, 0);       wait_idle();

        // R3 zero pulse treated as one; shortest cycle
        load_timing(0, 0, 3);
        xfer(1, 6, 1, 0, 16'h0F06, 0, 0, 0, 0, 0, 0);       wait_idle();
        xfer(0, 1, 0, 0, 0, 16'h99EE, 1, 0, 0, 0, 0);       wait_idle();

        // R4 long programmed cycle dominates
        load_timing(1, 3, 20);
        xfer(0, 2, 0, 1, 0, 16'hBEEF, 2, 0, 0, 0, 0);       wait_idle();

        // R11 load during a cycle in flight
        xfer(0, 3, 0, 1, 0, 16'h4321, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        load_timing(3, 5, 8);
        wait_idle();
        xfer(0, 4, 0, 1, 0, 16'h8001, 0, 0, 0, 0, 0);       wait_idle();

        // R11 load in the same clock as ACCEPT
        xfer(0, 5, 1, 1, 16'hCAFE, 0, 0, 1, 0, 2, 5);       wait_idle();
        xfer(1, 6, 0, 0, 0, 16'h3344, 0, 0, 0, 0, 0);       wait_idle();

        // Back to mode-0 style timing
        load_timing(4, 15, 30);
        xfer(0, 7, 1, 0, 16'h00EC, 0, 2, 0, 0, 0, 0);       wait_idle();

        chk(exp_q.size() == 0, "R4 all cycles completed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule